// File: doc/BRIEF.md
# Message Completion Interrupt Aggregator

This block gathers "message complete" events from 32 message objects and turns them into two interrupt requests, one for transmit and one for receive. Every object has a sticky completion flag and an interrupt enable bit. An event always sets its object's flag. It also raises the matching interrupt line if that object is enabled.

Software services the block through a small register port. It reads the completion flags and the enable bits as two 16-bit words each. It clears flags and interrupt bits by writing 1 to them. It finds the next object to service through a summary register, which reports the lowest-numbered object that is both enabled and pending. An interrupt bit is raised only by a new completion on an enabled object. Flags left pending never raise it again, so a handler should clear the per-object flags first and the interrupt bit last.

Top module: `msgdone_irq_agg`

## Requirements
- R1: A synchronous active-high reset clears all completion flags, all enable bits and both interrupt bits. After reset every register reads 0 and both interrupt outputs are low.
- R2: A completion event (`evt_valid` high, object index on `evt_obj`) sets that object's flag at the next clock edge. This happens whatever the object's enable bit is and whatever other flags are already set.
- R3: A completion on an enabled object raises `irq_tx` (when `evt_is_tx` = 1) or `irq_rx` (when `evt_is_tx` = 0) at the same edge that sets its flag. A completion on a disabled object raises neither line.
- R4: Address 4 is the interrupt register, with the transmit bit at bit 1 and the receive bit at bit 0. It reads the current interrupt bits, and writing 1 to a bit clears it.
- R5: An interrupt bit that has been cleared stays low while enabled flags remain pending. It rises again only on a new completion for an enabled object of that direction.
- R6: Address 5 is the read-only summary register. Bits [4:0] hold the lowest index whose enable bit and flag are both 1. Bit 5 is 1 when at least one such object exists. Bits [4:0] read 0 when none exists, and bits [15:6] always read 0.
- R7: The completion flags read at address 0 (objects 0 to 15, object n at bit n) and address 1 (objects 16 to 31). Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R8: The enable bits are read/write at address 2 (objects 0 to 15) and address 3 (objects 16 to 31), with the same bit layout as the flags.
- R9: When a completion and a write-1-to-clear hit the same completion flag, or the same interrupt bit, in one cycle, the flag or bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_valid | input | 1 | One-cycle completion event strobe |
| evt_obj | input | 5 | Index of the completing object |
| evt_is_tx | input | 1 | 1 = transmit completion, 0 = receive completion |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data, combinational from registered state |
| irq_tx | output | 1 | Transmit completion interrupt request |
| irq_rx | output | 1 | Receive completion interrupt request |

## Verification
The tests mix completions on disabled and enabled objects. This separates flag setting from interrupt raising, and shows the summary ignoring pending objects that are not enabled. Events land in both flag words and in both directions, so a swapped word or a swapped transmit/receive bit shows up in the readback. A completion that repeats an object already pending, arriving after its interrupt bit was cleared, separates "raised by a new event" from "re-raised by old flags". Same-cycle set and clear, and a reset taken mid-run, cover the priority and reset rules.

// File: rtl/msgdone_pkg.sv
package msgdone_pkg;

  // Interrupt register bit layout
  localparam int IRQ_RX_BIT = 0;
  localparam int IRQ_TX_BIT = 1;

  typedef enum logic [2:0] {
    RK_FLAG,
    RK_EN,
    RK_IRQ,
    RK_SUM,
    RK_NONE
  } reg_kind_t;

  // Map an address to a register kind, given the number of words per bank.
  function automatic reg_kind_t kind_of(input int unsigned addr, input int unsigned words);
    if (addr < words)              return RK_FLAG;
    else if (addr < 2 * words)     return RK_EN;
    else if (addr == 2 * words)    return RK_IRQ;
    else if (addr == 2 * words + 1) return RK_SUM;
    else                           return RK_NONE;
  endfunction

  // Word index within a bank for a flag or enable address.
  function automatic int unsigned word_of(input int unsigned addr, input int unsigned words);
    return (addr < words) ? addr : addr - words;
  endfunction

endpackage

// File: rtl/msgdone_lowest_enc.sv
module msgdone_lowest_enc #(
  parameter int N     = 32,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  always_comb begin
    idx = '0;
    any = |req;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/msgdone_flag_bank.sv
module msgdone_flag_bank #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)             flags[i] <= 1'b0;
      else if (set_vec[i]) flags[i] <= 1'b1;
      else if (clr_vec[i]) flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/msgdone_irq_bit.sv
module msgdone_irq_bit (
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic clr_req,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)          q <= 1'b0;
    else if (set_evt) q <= 1'b1;
    else if (clr_req) q <= 1'b0;
  end
endmodule

// File: rtl/msgdone_irq_agg.sv
module msgdone_irq_agg #(
  parameter int NUM_OBJ = 32,
  parameter int WORD_W  = 16,
  parameter int ADDR_W  = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       evt_valid,
  input  logic [$clog2(NUM_OBJ)-1:0] evt_obj,
  input  logic                       evt_is_tx,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [WORD_W-1:0]          wr_data,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [WORD_W-1:0]          rd_data,
  output logic                       irq_tx,
  output logic                       irq_rx
);
  import msgdone_pkg::*;

  localparam int IDX_W     = $clog2(NUM_OBJ);
  localparam int NUM_WORDS = NUM_OBJ / WORD_W;

  // Named internal events
  logic [NUM_OBJ-1:0] status_q;
  logic [NUM_OBJ-1:0] en_q;
  logic [NUM_OBJ-1:0] evt_set_vec;
  logic [NUM_OBJ-1:0] flag_clr_vec;
  logic [NUM_OBJ-1:0] pend_en_vec;
  logic               evt_enabled;
  logic               tx_set_evt;
  logic               rx_set_evt;
  logic               irq_wr;
  logic               irq_clr_tx;
  logic               irq_clr_rx;
  logic [IDX_W-1:0]   sum_idx;
  logic               sum_any;
  logic [WORD_W-1:0]  summary_word;
  reg_kind_t          wr_kind;
  reg_kind_t          rd_kind;
  int unsigned        wr_word;
  int unsigned        rd_word;

  assign wr_kind = kind_of(int'(wr_addr), NUM_WORDS);
  assign rd_kind = kind_of(int'(rd_addr), NUM_WORDS);
  assign wr_word = word_of(int'(wr_addr), NUM_WORDS);
  assign rd_word = word_of(int'(rd_addr), NUM_WORDS);

  // Completion event decode
  assign evt_set_vec = evt_valid ? (NUM_OBJ'(1) << evt_obj) : '0;
  assign evt_enabled = en_q[evt_obj];
  assign tx_set_evt  = evt_valid &  evt_is_tx & evt_enabled;
  assign rx_set_evt  = evt_valid & ~evt_is_tx & evt_enabled;

  // Write decode
  assign irq_wr     = wr_en && (wr_kind == RK_IRQ);
  assign irq_clr_tx = irq_wr & wr_data[IRQ_TX_BIT];
  assign irq_clr_rx = irq_wr & wr_data[IRQ_RX_BIT];

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    assign flag_clr_vec[w*WORD_W +: WORD_W] =
      (wr_en && wr_kind == RK_FLAG && wr_word == w) ? wr_data : '0;

    always_ff @(posedge clk) begin
      if (rst)
        en_q[w*WORD_W +: WORD_W] <= '0;
      else if (wr_en && wr_kind == RK_EN && wr_word == w)
        en_q[w*WORD_W +: WORD_W] <= wr_data;
    end
  end

  msgdone_flag_bank #(.N(NUM_OBJ)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .set_vec (evt_set_vec),
    .clr_vec (flag_clr_vec),
    .flags   (status_q)
  );

  msgdone_irq_bit u_irq_tx (
    .clk     (clk),
    .rst     (rst),
    .set_evt (tx_set_evt),
    .clr_req (irq_clr_tx),
    .q       (irq_tx)
  );

  msgdone_irq_bit u_irq_rx (
    .clk     (clk),
    .rst     (rst),
    .set_evt (rx_set_evt),
    .clr_req (irq_clr_rx),
    .q       (irq_rx)
  );

  // Summary of enabled pending objects
  assign pend_en_vec = status_q & en_q;

  msgdone_lowest_enc #(.N(NUM_OBJ), .IDX_W(IDX_W)) u_enc (
    .req (pend_en_vec),
    .idx (sum_idx),
    .any (sum_any)
  );

  always_comb begin
    summary_word = '0;
    summary_word[IDX_W-1:0] = sum_idx;
    summary_word[IDX_W]     = sum_any;
  end

  // Read mux
  always_comb begin
    rd_data = '0;
    unique case (rd_kind)
      RK_FLAG: rd_data = status_q[rd_word*WORD_W +: WORD_W];
      RK_EN:   rd_data = en_q[rd_word*WORD_W +: WORD_W];
      RK_IRQ: begin
        rd_data[IRQ_TX_BIT] = irq_tx;
        rd_data[IRQ_RX_BIT] = irq_rx;
      end
      RK_SUM:  rd_data = summary_word;
      default: rd_data = '0;
    endcase
  end

endmodule

// File: rtl/msgdone_irq_agg_chk.sv
module msgdone_irq_agg_chk #(
  parameter int NUM_OBJ = 32,
  parameter int WORD_W  = 16,
  parameter int ADDR_W  = 3
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       evt_valid,
  input logic [$clog2(NUM_OBJ)-1:0] evt_obj,
  input logic                       evt_is_tx,
  input logic                       wr_en,
  input logic [ADDR_W-1:0]          wr_addr,
  input logic [WORD_W-1:0]          wr_data,
  input logic                       irq_tx,
  input logic                       irq_rx,
  input logic [NUM_OBJ-1:0]         status_q,
  input logic [NUM_OBJ-1:0]         en_q,
  input logic [$clog2(NUM_OBJ)-1:0] sum_idx,
  input logic                       sum_any
);
  localparam int IRQ_ADDR = 2 * (NUM_OBJ / WORD_W);

  logic [NUM_OBJ-1:0] below_mask;
  assign below_mask = (NUM_OBJ'(1) << sum_idx) - NUM_OBJ'(1);

  // R2
  evt_flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    evt_valid |=> status_q[$past(evt_obj)]);

  // R3
  tx_irq_set_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_is_tx && en_q[evt_obj]) |=> irq_tx);

  // R3
  rx_irq_set_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && !evt_is_tx && en_q[evt_obj]) |=> irq_rx);

  // R4
  tx_irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_W'(IRQ_ADDR) && wr_data[1] &&
     !(evt_valid && evt_is_tx && en_q[evt_obj])) |=> !irq_tx);

  // R5
  tx_no_reassert_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_tx) |-> $past(evt_valid && evt_is_tx && en_q[evt_obj]));

  // R5
  rx_no_reassert_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_rx) |-> $past(evt_valid && !evt_is_tx && en_q[evt_obj]));

  // R6
  summary_hit_chk: assert property (@(posedge clk) disable iff (rst)
    sum_any |-> (status_q[sum_idx] && en_q[sum_idx]));

  // R6
  summary_lowest_chk: assert property (@(posedge clk) disable iff (rst)
    sum_any |-> ((status_q & en_q & below_mask) == '0));

endmodule

bind msgdone_irq_agg msgdone_irq_agg_chk #(
  .NUM_OBJ (NUM_OBJ),
  .WORD_W  (WORD_W),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .evt_valid (evt_valid),
  .evt_obj   (evt_obj),
  .evt_is_tx (evt_is_tx),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .irq_tx    (irq_tx),
  .irq_rx    (irq_rx),
  .status_q  (status_q),
  .en_q      (en_q),
  .sum_idx   (sum_idx),
  .sum_any   (sum_any)
);

// File: tb/msgdone_irq_agg_test.sv
module msgdone_irq_agg_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  localparam logic [1:0] OP_WR = 2'd0;
  localparam logic [1:0] OP_EV = 2'd1;
  localparam logic [1:0] OP_RD = 2'd2;

  // data for OP_EV: [4:0] object, [5] transmit; irq expectation is {tx, rx}
  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  req;
    logic [2:0]  addr;
    logic [15:0] data;
    logic [1:0]  irq;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t TBL [0:NV-1] = '{
    '{OP_RD, 4'd1, 3'd0, 16'h0000, 2'b00}, // R1 flags low clear
    '{OP_RD, 4'd1, 3'd5, 16'h0000, 2'b00}, // R1 summary clear
    '{OP_WR, 4'd8, 3'd2, 16'h0009, 2'b00}, // R8 enable objects 0 and 3
    '{OP_WR, 4'd8, 3'd3, 16'h8000, 2'b00}, // R8 enable object 31
    '{OP_RD, 4'd8, 3'd2, 16'h0009, 2'b00}, // R8
    '{OP_RD, 4'd8, 3'd3, 16'h8000, 2'b00}, // R8
    '{OP_EV, 4'd2, 3'd0, 16'h0005, 2'b00}, // R2 object 5 rx, disabled
    '{OP_RD, 4'd2, 3'd0, 16'h0020, 2'b00}, // R2 flag set, R3 no irq
    '{OP_RD, 4'd6, 3'd5, 16'h0000, 2'b00}, // R6 disabled object ignored
    '{OP_EV, 4'd3, 3'd0, 16'h003F, 2'b00}, // R3 object 31 tx, enabled
    '{OP_RD, 4'd7, 3'd1, 16'h8000, 2'b10}, // R7 high word
    '{OP_RD, 4'd6, 3'd5, 16'h003F, 2'b10}, // R6
    '{OP_RD, 4'd4, 3'd4, 16'h0002, 2'b10}, // R4 tx at bit 1
    '{OP_EV, 4'd3, 3'd0, 16'h0003, 2'b00}, // R3 object 3 rx, enabled
    '{OP_RD, 4'd2, 3'd0, 16'h0028, 2'b11}, // R2 other flags kept
    '{OP_RD, 4'd6, 3'd5, 16'h0023, 2'b11}, // R6 lowest is 3
    '{OP_WR, 4'd4, 3'd4, 16'h0003, 2'b00}, // R4 clear both
    '{OP_RD, 4'd5, 3'd4, 16'h0000, 2'b00}, // R5 stays low
    '{OP_RD, 4'd5, 3'd5, 16'h0023, 2'b00}, // R5 flags still pending
    '{OP_EV, 4'd5, 3'd0, 16'h0003, 2'b00}, // R5 new completion object 3 rx
    '{OP_RD, 4'd5, 3'd4, 16'h0001, 2'b01}, // R5 rx raised again
    '{OP_WR, 4'd7, 3'd0, 16'h0008, 2'b00}, // R7 clear object 3
    '{OP_RD, 4'd7, 3'd0, 16'h0020, 2'b01}, // R7
    '{OP_RD, 4'd6, 3'd5, 16'h003F, 2'b01}, // R6 next is 31
    '{OP_WR, 4'd7, 3'd1, 16'h0000, 2'b00}, // R7 write zero
    '{OP_RD, 4'd7, 3'd1, 16'h8000, 2'b01}, // R7 unchanged
    '{OP_WR, 4'd7, 3'd1, 16'h8000, 2'b00}, // R7 clear object 31
    '{OP_RD, 4'd6, 3'd5, 16'h0000, 2'b01}  // R6 none pending, index 0
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        evt_valid = 1'b0;
  logic [4:0]  evt_obj = '0;
  logic        evt_is_tx = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        irq_tx;
  logic        irq_rx;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  msgdone_irq_agg uut (
    .clk       (clk),
    .rst       (rst),
    .evt_valid (evt_valid),
    .evt_obj   (evt_obj),
    .evt_is_tx (evt_is_tx),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .irq_tx    (irq_tx),
    .irq_rx    (irq_rx)
  );

  task automatic check_read(input logic [2:0] a, input logic [15:0] exp_d,
                            input logic [1:0] exp_i, input int rq);
    rd_addr = a;
    #1;
    n_checks++;
    if (rd_data !== exp_d || {irq_tx, irq_rx} !== exp_i) begin
      n_fail++;
      $display("FAIL R%0d addr %0d: data %h irq %b, expected data %h irq %b",
               rq, a, rd_data, {irq_tx, irq_rx}, exp_d, exp_i);
    end
  endtask

  task automatic tick;
    @(negedge clk);
    evt_valid = 1'b0;
    wr_en     = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      case (TBL[i].op)
        OP_WR: begin
          wr_en = 1'b1; wr_addr = TBL[i].addr; wr_data = TBL[i].data;
          tick();
        end
        OP_EV: begin
          evt_valid = 1'b1; evt_obj = TBL[i].data[4:0]; evt_is_tx = TBL[i].data[5];
          tick();
        end
        default: check_read(TBL[i].addr, TBL[i].data, TBL[i].irq, int'(TBL[i].req));
      endcase
    end

    // R9: completion on object 0 (rx, enabled) and clear of its flag in one cycle
    evt_valid = 1'b1; evt_obj = 5'd0; evt_is_tx = 1'b0;
    wr_en = 1'b1; wr_addr = 3'd0; wr_data = 16'h0001;
    tick();
    check_read(3'd0, 16'h0021, 2'b01, 9);
    check_read(3'd5, 16'h0020, 2'b01, 9);

    // R9: completion on object 0 rx together with clear of the rx interrupt bit
    evt_valid = 1'b1; evt_obj = 5'd0; evt_is_tx = 1'b0;
    wr_en = 1'b1; wr_addr = 3'd4; wr_data = 16'h0001;
    tick();
    check_read(3'd4, 16'h0001, 2'b01, 9);

    // R3: tx completion on disabled object 20 sets flag but no irq
    evt_valid = 1'b1; evt_obj = 5'd20; evt_is_tx = 1'b1;
    tick();
    check_read(3'd1, 16'h0010, 2'b01, 3);

    // R1: reset taken mid-run clears everything
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check_read(3'd0, 16'h0000, 2'b00, 1);
    check_read(3'd1, 16'h0000, 2'b00, 1);
    check_read(3'd2, 16'h0000, 2'b00, 1);
    check_read(3'd3, 16'h0000, 2'b00, 1);
    check_read(3'd4, 16'h0000, 2'b00, 1);
    check_read(3'd5, 16'h0000, 2'b00, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule